// File: doc/BRIEF.md
# Li-ion Charge Phase Controller

This block sequences one battery charge cycle for a switched-mode lithium-ion charger. It reads digitised comparator flags from the analog front end: battery below the precharge threshold, battery below the recharge threshold, voltage loop in regulation, taper current reached, overvoltage, and two temperature window flags. It also reads a power-good flag, an active-low charge enable and a timer enable. From these it selects the regulation mode for the analog loops and gates the PWM. It drives a small detect current while in a fault, a discharge pulse after termination, and two active-low status lines.

The cycle runs through precharge, constant-current and constant-voltage phases and ends in a complete state. The block holds a precharge safety timer and a programmable fast-charge safety timer. Both freeze while a temperature suspend is in force. Every timed decision advances on a 1 ms tick-enable input, so timer lengths are counted in ticks and the bench can shorten them through parameters. The block restarts a cycle on a deglitched recharge, on power-good return with a partly discharged battery, on a falling edge of charge enable, and on a rising edge of timer enable.

Top module: `chg_phase_ctrl`

## Requirements
- R1: While reset is active or `pwr_good` is low, the block sleeps. In sleep, `reg_mode`=0, `pwm_en`=0, `detect_en`=0 and `dis_en`=0, and both status lines are high. One clock after `pwr_good` returns, it starts a cycle if `bat_rch`=1. Otherwise it enters the complete state.
- R2: A cycle start selects precharge (`reg_mode`=1) when `bat_low`=1, and constant current (`reg_mode`=2) otherwise. The start also clears both safety timers. `pwm_en` is high exactly in modes 1, 2 and 3.
- R3: Precharge moves to constant current only after `bat_low`=0 has been seen on DGL_TICKS consecutive ticks. Any cycle with `bat_low`=1 restarts that count.
- R4: If precharge lasts PRE_TICKS timer ticks, the block enters a timeout fault with PWM off.
- R5: Constant current moves to constant voltage (`reg_mode`=3) on the clock after `at_vreg`=1. When the fast-charge timer counts `fast_lim` ticks across modes 2 and 3, the block enters a timeout fault.
- R6: In constant voltage with `tmr_en`=1, `taper`=1 held for DGL_TICKS consecutive ticks ends the charge. The block then enters the complete state, and `dis_en` stays high for DIS_TICKS ticks.
- R7: The status lines read as follows. Charging (modes 1 to 3) gives `stat1_n`=0 and `stat2_n`=1. Complete gives `stat1_n`=1 and `stat2_n`=0. Sleep, suspend and the faults drive both lines high.
- R8: In the complete state, `bat_rch`=1 held for DGL_TICKS consecutive ticks starts a new cycle.
- R9: `chg_en_n`=1 forces sleep on the next clock. The clock after it returns low starts a new cycle with all timers and faults cleared.
- R10: With `tmr_en`=0, both safety timers stop and termination cannot occur. A rising edge of `tmr_en` starts a new cycle with cleared timers, unless the block is asleep or in the overvoltage fault.
- R11: `ovp`=1 during a charge phase or the complete state enters an overvoltage fault on the next clock. In that fault, PWM and both status lines are off and `detect_en`=0. The fault is left only when `bat_rch`=1.
- R12: When a timeout fault is entered with `bat_rch`=1, `detect_en` is high until `bat_rch` goes to 0. After that, and for a fault entered with `bat_rch`=0, the fault clears and a new cycle starts on the clock after `bat_rch`=1.
- R13: `temp_run_ok`=0 during a charge phase enters suspend: PWM off, status lines high, timers held. Suspend resumes the same phase only when `temp_start_ok`=1. A cycle start with `temp_start_ok`=0 also enters suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 1 ms time-base enable |
| pwr_good | input | 1 | Supply valid flag |
| chg_en_n | input | 1 | Active-low charge enable |
| tmr_en | input | 1 | Enables safety timers and termination |
| bat_low | input | 1 | Battery below precharge threshold |
| bat_rch | input | 1 | Battery below recharge threshold |
| at_vreg | input | 1 | Voltage loop has taken control |
| taper | input | 1 | Charge current below termination level |
| ovp | input | 1 | Battery overvoltage |
| temp_start_ok | input | 1 | Temperature inside the cycle-start window |
| temp_run_ok | input | 1 | Temperature inside the in-cycle window |
| fast_lim | input | TW | Fast-charge timer length in ticks |
| reg_mode | output | 2 | 0 off, 1 precharge, 2 constant current, 3 constant voltage |
| pwm_en | output | 1 | Modulator enable |
| detect_en | output | 1 | Fault detect current enable |
| dis_en | output | 1 | Termination discharge pulse |
| stat1_n | output | 1 | Active-low charging indicator |
| stat2_n | output | 1 | Active-low complete indicator |

## Verification
Several properties are checked on every clock. Sleep on low power-good or high enable leaves every output off. Overvoltage drops the PWM at once. The detect current never coincides with PWM or status. Precharge never reaches constant current while the low flag is set. Termination never happens with timers disabled. A completion straight from constant voltage always raises the discharge pulse. Only the bench scenarios can show the exact tick counts at which timers and deglitch filters fire. They also cover the freeze of the precharge timer across suspend, the arming sequence of the timeout fault, and the difference between a power-good restart and an enable restart. Random tick gaps and recharge glitches exercise the deglitch counting against a bench model.

// File: rtl/chg_phase_ctrl.sv
module chg_phase_ctrl #(
  parameter int TW        = 26,
  parameter int DGL_TICKS = 30,
  parameter int PRE_TICKS = 1800000,
  parameter int DIS_TICKS = 262
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pwr_good,
  input  logic          chg_en_n,
  input  logic          tmr_en,
  input  logic          bat_low,
  input  logic          bat_rch,
  input  logic          at_vreg,
  input  logic          taper,
  input  logic          ovp,
  input  logic          temp_start_ok,
  input  logic          temp_run_ok,
  input  logic [TW-1:0] fast_lim,
  output logic [1:0]    reg_mode,
  output logic          pwm_en,
  output logic          detect_en,
  output logic          dis_en,
  output logic          stat1_n,
  output logic          stat2_n
);
  localparam int DW = $clog2(DGL_TICKS + 1);
  localparam int PW = $clog2(PRE_TICKS + 1);
  localparam int SW = $clog2(DIS_TICKS + 1);

  typedef enum logic [2:0] {
    S_SLEEP, S_PRE, S_FAST, S_CV, S_DONE, S_SUSP, S_FTO, S_FOV
  } st_t;

  st_t st, nxt, rsm, tgt;
  logic          from_por, armed, tmr_q, start, dg_cond;
  logic [DW-1:0] dg_cnt;
  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] fast_cnt;
  logic [SW-1:0] dis_cnt;

  wire active    = pwr_good & ~chg_en_n;
  wire tmr_rise  = tmr_en & ~tmr_q;
  wire tk_t      = tick & tmr_en;
  wire charging  = (st == S_PRE) | (st == S_FAST) | (st == S_CV);
  wire dg_fire   = dg_cond & tick & (dg_cnt == DW'(DGL_TICKS - 1));
  wire pre_fire  = tk_t & (pre_cnt == PW'(PRE_TICKS - 1));
  wire fast_fire = tk_t & (({1'b0, fast_cnt} + (TW+1)'(1)) >= {1'b0, fast_lim});

  assign tgt = bat_low ? S_PRE : S_FAST;

  always_comb begin
    case (st)
      S_PRE:   dg_cond = ~bat_low;
      S_CV:    dg_cond = taper & tmr_en;
      S_DONE:  dg_cond = bat_rch;
      default: dg_cond = 1'b0;
    endcase
  end

  always_comb begin
    nxt   = st;
    start = 1'b0;
    if (!active) nxt = S_SLEEP;
    else begin
      case (st)
        S_SLEEP: if (!from_por || bat_rch) start = 1'b1; else nxt = S_DONE;
        S_PRE: begin
          if (ovp)               nxt = S_FOV;
          else if (!temp_run_ok) nxt = S_SUSP;
          else if (pre_fire)     nxt = S_FTO;
          else if (dg_fire)      nxt = S_FAST;
        end
        S_FAST: begin
          if (ovp)               nxt = S_FOV;
          else if (!temp_run_ok) nxt = S_SUSP;
          else if (fast_fire)    nxt = S_FTO;
          else if (at_vreg)      nxt = S_CV;
        end
        S_CV: begin
          if (ovp)               nxt = S_FOV;
          else if (!temp_run_ok) nxt = S_SUSP;
          else if (fast_fire)    nxt = S_FTO;
          else if (dg_fire)      nxt = S_DONE;
        end
        S_DONE:  if (ovp) nxt = S_FOV; else if (dg_fire) start = 1'b1;
        S_SUSP:  if (temp_start_ok) nxt = rsm;
        S_FTO:   if (armed && bat_rch) start = 1'b1;
        S_FOV:   if (bat_rch) start = 1'b1;
        default: nxt = S_SLEEP;
      endcase
      if (tmr_rise && !ovp && st != S_SLEEP && st != S_FOV) start = 1'b1;
      if (start) nxt = temp_start_ok ? tgt : S_SUSP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_SLEEP;
      rsm      <= S_PRE;
      from_por <= 1'b1;
      armed    <= 1'b0;
      tmr_q    <= 1'b0;
      dg_cnt   <= '0;
      pre_cnt  <= '0;
      fast_cnt <= '0;
      dis_cnt  <= '0;
    end else begin
      st    <= nxt;
      tmr_q <= tmr_en;

      if (!pwr_good)     from_por <= 1'b1;
      else if (chg_en_n) from_por <= 1'b0;

      if (nxt == S_SUSP && st != S_SUSP) rsm <= start ? tgt : st;

      if (nxt == S_FTO && st != S_FTO) armed <= ~bat_rch;
      else if (st == S_FTO && !bat_rch) armed <= 1'b1;

      if (nxt != st || !dg_cond) dg_cnt <= '0;
      else if (tick)             dg_cnt <= dg_cnt + DW'(1);

      if (start || nxt == S_SLEEP) pre_cnt <= '0;
      else if (st == S_PRE && nxt == S_PRE && tk_t) pre_cnt <= pre_cnt + PW'(1);

      if (start || nxt == S_SLEEP) fast_cnt <= '0;
      else if ((st == S_FAST || st == S_CV) && (nxt == S_FAST || nxt == S_CV) && tk_t)
        fast_cnt <= fast_cnt + TW'(1);

      if (nxt != S_DONE)               dis_cnt <= '0;
      else if (st == S_CV)             dis_cnt <= SW'(DIS_TICKS);
      else if (tick && dis_cnt != '0)  dis_cnt <= dis_cnt - SW'(1);
    end
  end

  always_comb begin
    case (st)
      S_PRE:   reg_mode = 2'd1;
      S_FAST:  reg_mode = 2'd2;
      S_CV:    reg_mode = 2'd3;
      default: reg_mode = 2'd0;
    endcase
  end

  assign pwm_en    = charging;
  assign stat1_n   = ~charging;
  assign stat2_n   = (st != S_DONE);
  assign detect_en = (st == S_FTO) & ~armed;
  assign dis_en    = (dis_cnt != '0);

  assert_sleep_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (reg_mode == 2'd0 && !pwm_en && !detect_en && !dis_en && stat1_n && stat2_n));

  assert_pre_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode == 2'd1 && bat_low) |=> reg_mode != 2'd2);

  assert_discharge_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stat2_n) && $past(reg_mode) == 2'd3) |-> dis_en);

  assert_enable_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en_n |=> (!pwm_en && !detect_en));

  assert_no_term_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && reg_mode == 2'd3) |=> stat2_n);

  assert_ovp_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp && pwm_en) |=> !pwm_en);

  assert_detect_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    detect_en |-> (!pwm_en && stat1_n && stat2_n));
endmodule

// File: tb/chg_phase_ctrl_test.sv
module chg_phase_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 26;
  localparam int DGL = 4;
  localparam int PRE = 20;
  localparam int DIS = 6;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, pwr_good = 1'b1, chg_en_n = 1'b0;
  logic tmr_en = 1'b1, bat_low = 1'b1, bat_rch = 1'b1, at_vreg = 1'b0, taper = 1'b0;
  logic ovp = 1'b0, temp_start_ok = 1'b1, temp_run_ok = 1'b1;
  logic [TW-1:0] fast_lim = TW'(40);
  logic [1:0] reg_mode;
  logic pwm_en, detect_en, dis_en, stat1_n, stat2_n;
  int n_chk = 0, n_fail = 0;

  chg_phase_ctrl #(.TW(TW), .DGL_TICKS(DGL), .PRE_TICKS(PRE), .DIS_TICKS(DIS)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good), .chg_en_n(chg_en_n),
    .tmr_en(tmr_en), .bat_low(bat_low), .bat_rch(bat_rch), .at_vreg(at_vreg),
    .taper(taper), .ovp(ovp), .temp_start_ok(temp_start_ok), .temp_run_ok(temp_run_ok),
    .fast_lim(fast_lim), .reg_mode(reg_mode), .pwm_en(pwm_en), .detect_en(detect_en),
    .dis_en(dis_en), .stat1_n(stat1_n), .stat2_n(stat2_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // phase: 0 off, 1 precharge, 2 const current, 3 const voltage, 4 complete, 5 fault with detect
  function automatic logic [5:0] exp_vec(input int phase);
    case (phase)
      1:       return {2'd1, 1'b1, 1'b0, 1'b1, 1'b0};
      2:       return {2'd2, 1'b1, 1'b0, 1'b1, 1'b0};
      3:       return {2'd3, 1'b1, 1'b0, 1'b1, 1'b0};
      4:       return {2'd0, 1'b0, 1'b1, 1'b0, 1'b0};
      5:       return {2'd0, 1'b0, 1'b1, 1'b1, 1'b1};
      default: return {2'd0, 1'b0, 1'b1, 1'b1, 1'b0};
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int phase);
    logic [5:0] act;
    act = {reg_mode, pwm_en, stat1_n, stat2_n, detect_en};
    n_chk++;
    if (act !== exp_vec(phase)) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp_vec(phase));
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    int cnt;
    bit fired;
    void'($urandom(32'd1234));
    step(3);
    chk("R1 reset", 0);
    chk_bit("R1 reset dis", dis_en, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R2 start precharge", 1);

    bat_low = 1'b0; step(2); bat_low = 1'b1; step(1); bat_low = 1'b0;
    step(3); chk("R3 glitch restarts count", 1);
    step(1); chk("R3 fast after deglitch", 2);

    at_vreg = 1'b1; bat_rch = 1'b0;
    step(1); chk("R5 enter const voltage", 3);

    taper = 1'b1;
    step(3); chk("R6 taper not yet", 3);
    step(1); chk("R6 R7 complete", 4);
    chk_bit("R6 discharge on", dis_en, 1'b1);
    taper = 1'b0; at_vreg = 1'b0;
    step(5); chk_bit("R6 discharge still on", dis_en, 1'b1);
    step(1); chk_bit("R6 discharge ended", dis_en, 1'b0);

    bat_rch = 1'b1;
    step(3); chk("R8 recharge not yet", 4);
    step(1); chk("R8 recharge restart", 2);

    step(39); chk("R5 fast timer not expired", 2);
    step(1); chk("R5 R12 timeout with detect", 5);
    bat_rch = 1'b0; step(1); chk("R12 detect off once above", 0);
    bat_rch = 1'b1; step(1); chk("R12 fault cleared", 2);

    tmr_en = 1'b0;
    step(60); chk("R10 timer frozen", 2);
    at_vreg = 1'b1; step(1); chk("R10 const voltage", 3);
    taper = 1'b1; step(10); chk("R10 no termination", 3);
    taper = 1'b0; at_vreg = 1'b0; tmr_en = 1'b1;
    step(1); chk("R10 timer re-enable restart", 2);

    chg_en_n = 1'b1; step(1); chk("R9 sleep on disable", 0);
    chg_en_n = 1'b0; bat_low = 1'b1; step(1); chk("R9 restart on enable", 1);
    step(19); chk("R4 precharge timer running", 1);
    step(1); chk("R4 precharge timeout", 5);

    chg_en_n = 1'b1; step(1); chk("R9 fault cleared by sleep", 0);
    chg_en_n = 1'b0; step(1); chk("R9 new precharge", 1);
    step(10);
    temp_run_ok = 1'b0; step(1); chk("R13 suspend", 0);
    temp_run_ok = 1'b1; temp_start_ok = 1'b0; step(3); chk("R13 needs start window", 0);
    temp_start_ok = 1'b1; step(1); chk("R13 resume precharge", 1);
    step(9); chk("R13 timer held not reset", 1);
    step(1); chk("R13 R4 timeout after held count", 5);

    chg_en_n = 1'b1; step(1); chg_en_n = 1'b0; bat_low = 1'b0;
    step(1); chk("R2 start fast", 2);
    ovp = 1'b1; step(1); chk("R11 overvoltage off", 0);
    ovp = 1'b0; bat_rch = 1'b0; step(3); chk("R11 held until recharge", 0);
    bat_rch = 1'b1; step(1); chk("R11 cleared on recharge", 2);

    pwr_good = 1'b0; step(1); chk("R1 sleep on power loss", 0);
    bat_rch = 1'b0; pwr_good = 1'b1; step(1); chk("R1 return full battery", 4);
    pwr_good = 1'b0; step(1); bat_rch = 1'b1; pwr_good = 1'b1;
    step(1); chk("R1 return low battery", 2);

    temp_start_ok = 1'b0; chg_en_n = 1'b1; step(1); chg_en_n = 1'b0;
    step(1); chk("R13 start outside window", 0);
    temp_start_ok = 1'b1; step(1); chk("R13 start resumes", 2);

    for (int it = 0; it < 8; it++) begin
      pwr_good = 1'b0; step(1);
      bat_rch = 1'b0; pwr_good = 1'b1; step(1);
      chk("R8 random setup complete", 4);
      cnt = 0; fired = 1'b0;
      for (int c = 0; c < 200 && !fired; c++) begin
        tick = 1'($urandom % 2);
        bat_rch = (($urandom % 4) != 0);
        if (!bat_rch) cnt = 0;
        else if (tick) begin
          if (cnt == DGL - 1) fired = 1'b1;
          else cnt++;
        end
        step(1);
        chk("R8 random recharge deglitch", fired ? 2 : 4);
      end
      tick = 1'b1;
    end
    finish_run();
  end
endmodule